// File: doc/BRIEF.md
# Boundary Scan Register with Pin Control

This block is the chain of boundary-scan cells that sits between the core logic and the device pins. Every output pin owns two cells: one for the data value and one for the output enable. Every input pin owns one capture cell. A test access port controller supplies the data-register strobes (capture, shift, update). An instruction decoder supplies four mode flags: sample, external test, high impedance and clamp. Both of those sit outside this block. From them, the block decides what the pins see and presents the low end of the chain as the serial output.

While sample or external test is selected, the chain is in the scan path. A capture strobe snapshots the pin inputs and the core-side output values and enables. Each shift strobe moves the chain one cell toward the serial output. An update strobe, acting on the falling edge of the test clock, copies the output-side cells into parallel latches. External test and clamp drive the pins from those latches. Because sample fills the same latches, the pins already hold known values when external test begins. High impedance forces every enable off, whatever is latched.

Top module: `bsr_top`

## Requirements
- R1: An active-low `trst_n` asynchronously clears the chain and the update latches, so a following external test drives all pin outputs and enables to 0.
- R2: With neither external test nor clamp selected, `pin_out` equals `core_out`. With high impedance also off, `pin_oe` equals `core_oe`. `core_in` always equals `pin_in`. Sample mode alone never disturbs these paths.
- R3: The chain order is fixed. Input cell i is at index i, output j's data cell is at index N_IN+2j, and its enable cell is at index N_IN+2j+1. A capture strobe with sample or external test selected loads `pin_in`, `core_out` and `core_oe` into these cells on the rising test-clock edge.
- R4: `tdo` shows chain index 0. A shift strobe with sample or external test selected, and no capture, moves every cell one index down on the rising edge and loads `tdi` into the top index.
- R5: An update strobe with sample or external test selected copies the output-side cells (indices N_IN upward) into the update latches on the falling test-clock edge.
- R6: During external test, `pin_out[j]` and `pin_oe[j]` come from the latched data and enable cells of output j. Shifting does not change them until the next update.
- R7: Values latched under sample appear on the pins in the first cycle external test is selected.
- R8: High impedance forces every `pin_oe` bit to 0, whatever the mode or latch contents.
- R9: Clamp drives the pins from the update latches. Capture, shift and update strobes leave the chain and the latches unchanged.
- R10: The `tlr` flag clears the update latches on the falling test-clock edge.
- R11: With neither sample nor external test selected, all strobes leave the chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | Controller is in the test-logic-reset state |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| mode_sample | input | 1 | Sample/preload instruction active |
| mode_extest | input | 1 | External test instruction active |
| mode_highz | input | 1 | High-impedance instruction active |
| mode_clamp | input | 1 | Clamp instruction active |
| tdi | input | 1 | Serial data into the top of the chain |
| tdo | output | 1 | Serial data from chain index 0 |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_out | output | N_OUT | Values driven toward the pins |
| pin_oe | output | N_OUT | Enables driven toward the pins |
| pin_in | input | N_IN | Values arriving from the input pins |
| core_in | output | N_IN | Input values passed to the core |

## Verification
The bench preloads a pattern under sample and then selects external test. A design whose latches are not shared would show zeros or stale values in that first cycle. During a second scan under external test, it checks that the pins hold steady while the chain shifts. A design that drove pins from the shift stage would let them ripple. With clamp, and with no mode selected, it fires every strobe and confirms that `tdo` and the pins stay put. A design that let those modes into the scan path would corrupt the latches. Finally, it asserts high impedance on top of a live external test. It also pulses `tlr` and expects zeroed pins, which catches an enable override with the wrong priority or a missing latch clear.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } chain_op_e;

    typedef struct packed {
        logic from_latch;
        logic force_off;
    } pin_ctl_t;

endpackage

// File: rtl/bsr_ctl.sv
module bsr_ctl
    import bsr_pkg::*;
(
    input  logic      capture_dr,
    input  logic      shift_dr,
    input  logic      update_dr,
    input  logic      mode_sample,
    input  logic      mode_extest,
    input  logic      mode_highz,
    input  logic      mode_clamp,
    output chain_op_e chain_op,
    output logic      upd_load,
    output pin_ctl_t  pin_ctl
);

    logic in_path;

    always_comb begin
        in_path = mode_sample | mode_extest;
        if (in_path && capture_dr) begin
            chain_op = OP_CAPTURE;
        end else if (in_path && shift_dr) begin
            chain_op = OP_SHIFT;
        end else begin
            chain_op = OP_HOLD;
        end
        upd_load           = in_path & update_dr;
        pin_ctl.from_latch = mode_extest | mode_clamp;
        pin_ctl.force_off  = mode_highz;
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int LEN = 12
) (
    input  logic           tck,
    input  logic           trst_n,
    input  chain_op_e      chain_op,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] cells,
    output logic           tdo
);

    typedef struct packed {
        logic [LEN-1:0] cells;
    } chain_s;

    chain_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (chain_op)
            OP_CAPTURE: st_d.cells = cap_vec;
            OP_SHIFT:   st_d.cells = {tdi, st_q.cells[LEN-1:1]};
            default:    st_d.cells = st_q.cells;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells = st_q.cells;
    assign tdo   = st_q.cells[0];

endmodule

// File: rtl/bsr_latch.sv
module bsr_latch #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tlr,
    input  logic         upd_load,
    input  logic [W-1:0] shift_val,
    output logic [W-1:0] held
);

    typedef struct packed {
        logic [W-1:0] bits;
    } latch_s;

    latch_s lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (tlr) begin
            lt_d.bits = '0;
        end else if (upd_load) begin
            lt_d.bits = shift_val;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            lt_q <= '0;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign held = lt_q.bits;

endmodule

// File: rtl/bsr_pinmux.sv
module bsr_pinmux
    import bsr_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  pin_ctl_t           pin_ctl,
    input  logic [N_OUT-1:0]   core_out,
    input  logic [N_OUT-1:0]   core_oe,
    input  logic [2*N_OUT-1:0] held,
    output logic [N_OUT-1:0]   pin_out,
    output logic [N_OUT-1:0]   pin_oe
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_pin
        always_comb begin
            pin_out[j] = pin_ctl.from_latch ? held[2*j] : core_out[j];
            if (pin_ctl.force_off) begin
                pin_oe[j] = 1'b0;
            end else begin
                pin_oe[j] = pin_ctl.from_latch ? held[2*j+1] : core_oe[j];
            end
        end
    end

endmodule

// File: rtl/bsr_top.sv
module bsr_top
    import bsr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tlr,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             mode_sample,
    input  logic             mode_extest,
    input  logic             mode_highz,
    input  logic             mode_clamp,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in
);

    localparam int OUT_CELLS = 2 * N_OUT;
    localparam int LEN       = N_IN + OUT_CELLS;

    chain_op_e            chain_op;
    logic                 upd_load;
    pin_ctl_t             pin_ctl;
    logic [LEN-1:0]       cap_vec;
    logic [LEN-1:0]       chain_bits;
    logic [OUT_CELLS-1:0] upd_bits;

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign cap_vec[i] = pin_in[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
        assign cap_vec[N_IN+2*j]   = core_out[j];
        assign cap_vec[N_IN+2*j+1] = core_oe[j];
    end

    assign core_in = pin_in;

    bsr_ctl u_ctl (
        .capture_dr  (capture_dr),
        .shift_dr    (shift_dr),
        .update_dr   (update_dr),
        .mode_sample (mode_sample),
        .mode_extest (mode_extest),
        .mode_highz  (mode_highz),
        .mode_clamp  (mode_clamp),
        .chain_op    (chain_op),
        .upd_load    (upd_load),
        .pin_ctl     (pin_ctl)
    );

    bsr_chain #(.LEN(LEN)) u_chain (
        .tck      (tck),
        .trst_n   (trst_n),
        .chain_op (chain_op),
        .tdi      (tdi),
        .cap_vec  (cap_vec),
        .cells    (chain_bits),
        .tdo      (tdo)
    );

    bsr_latch #(.W(OUT_CELLS)) u_latch (
        .tck       (tck),
        .trst_n    (trst_n),
        .tlr       (tlr),
        .upd_load  (upd_load),
        .shift_val (chain_bits[LEN-1:N_IN]),
        .held      (upd_bits)
    );

    bsr_pinmux #(.N_OUT(N_OUT)) u_pinmux (
        .pin_ctl  (pin_ctl),
        .core_out (core_out),
        .core_oe  (core_oe),
        .held     (upd_bits),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input logic                     tck,
    input logic                     trst_n,
    input logic                     tlr,
    input logic                     capture_dr,
    input logic                     shift_dr,
    input logic                     update_dr,
    input logic                     mode_sample,
    input logic                     mode_extest,
    input logic                     mode_highz,
    input logic                     mode_clamp,
    input logic                     tdi,
    input logic [N_OUT-1:0]         core_out,
    input logic [N_OUT-1:0]         core_oe,
    input logic [N_OUT-1:0]         pin_out,
    input logic [N_OUT-1:0]         pin_oe,
    input logic [N_IN+2*N_OUT-1:0]  chain_bits,
    input logic [2*N_OUT-1:0]       upd_bits
);

    localparam int LEN = N_IN + 2 * N_OUT;

    logic in_path;
    assign in_path = mode_sample | mode_extest;

    // R8: high impedance turns every driver off
    a_r8_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
        mode_highz |-> (pin_oe == '0));

    // R2: functional path when pins are not latch-driven
    a_r2_out_follow: assert property (@(posedge tck) disable iff (!trst_n)
        (!mode_extest && !mode_clamp) |-> (pin_out == core_out));

    a_r2_oe_follow: assert property (@(posedge tck) disable iff (!trst_n)
        (!mode_extest && !mode_clamp && !mode_highz) |-> (pin_oe == core_oe));

    // R4: one-position shift toward the serial output
    a_r4_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
        (in_path && shift_dr && !capture_dr) |=>
            (chain_bits == {$past(tdi), $past(chain_bits[LEN-1:1])}));

    // R11 and R9: chain frozen outside the scan path
    a_r11_chain_hold: assert property (@(posedge tck) disable iff (!trst_n)
        !in_path |=> $stable(chain_bits));

    // R5: latches carry the output-side cells after an update
    a_r5_update_copy: assert property (@(posedge tck) disable iff (!trst_n)
        (in_path && update_dr && !tlr) |-> (upd_bits == chain_bits[LEN-1:N_IN]));

    // R10: test-logic-reset empties the latches
    a_r10_tlr_clear: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |-> (upd_bits == '0));

    // R9: clamp drives data pins from the latches
    for (genvar j = 0; j < N_OUT; j++) begin : g_clamp
        a_r9_clamp_data: assert property (@(posedge tck) disable iff (!trst_n)
            mode_clamp |-> (pin_out[j] == upd_bits[2*j]));
    end

endmodule

bind bsr_top bsr_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tlr         (tlr),
    .capture_dr  (capture_dr),
    .shift_dr    (shift_dr),
    .update_dr   (update_dr),
    .mode_sample (mode_sample),
    .mode_extest (mode_extest),
    .mode_highz  (mode_highz),
    .mode_clamp  (mode_clamp),
    .tdi         (tdi),
    .core_out    (core_out),
    .core_oe     (core_oe),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .chain_bits  (chain_bits),
    .upd_bits    (upd_bits)
);

// File: tb/tb_bsr_top.sv
`timescale 1ns/1ps
module tb_bsr_top;

    localparam int NI  = 4;
    localparam int NO  = 4;
    localparam int LEN = NI + 2 * NO;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tlr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic mode_sample = 1'b0, mode_extest = 1'b0, mode_highz = 1'b0, mode_clamp = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic [NO-1:0] core_out = '0, core_oe = '0, pin_out, pin_oe;
    logic [NI-1:0] pin_in = '0, core_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 tck = ~tck;   // 125 MHz

    bsr_top #(.N_IN(NI), .N_OUT(NO)) dut (
        .tck(tck), .trst_n(trst_n), .tlr(tlr),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .mode_sample(mode_sample), .mode_extest(mode_extest),
        .mode_highz(mode_highz), .mode_clamp(mode_clamp),
        .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe),
        .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in(pin_in), .core_in(core_in)
    );

    // reference model: scan path as a bit vector, index 0 at the serial output
    logic [LEN-1:0]  m_chain = '0;
    logic [2*NO-1:0] m_upd   = '0;

    function automatic logic [LEN-1:0] snap();
        logic [LEN-1:0] v;
        for (int i = 0; i < NI; i++) v[i] = pin_in[i];
        for (int j = 0; j < NO; j++) begin
            v[NI+2*j]   = core_out[j];
            v[NI+2*j+1] = core_oe[j];
        end
        return v;
    endfunction

    function automatic logic [NO-1:0] data_of(logic [2*NO-1:0] v);
        logic [NO-1:0] r;
        for (int j = 0; j < NO; j++) r[j] = v[2*j];
        return r;
    endfunction

    function automatic logic [NO-1:0] en_of(logic [2*NO-1:0] v);
        logic [NO-1:0] r;
        for (int j = 0; j < NO; j++) r[j] = v[2*j+1];
        return r;
    endfunction

    always @(posedge tck or negedge trst_n) begin
        if (!trst_n) m_chain <= '0;
        else if (mode_sample || mode_extest) begin
            if (capture_dr)    m_chain <= snap();
            else if (shift_dr) m_chain <= {tdi, m_chain[LEN-1:1]};
        end
    end

    always @(negedge tck or negedge trst_n) begin
        if (!trst_n) m_upd <= '0;
        else if (tlr) m_upd <= '0;
        else if (update_dr && (mode_sample || mode_extest)) m_upd <= m_chain[LEN-1:NI];
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    initial begin
        forever begin
            @(posedge tck);
            #3;
            if (!done) begin
                logic          latched;
                logic [NO-1:0] eo, ee;
                latched = mode_extest | mode_clamp;
                eo = latched ? data_of(m_upd) : core_out;
                ee = mode_highz ? '0 : (latched ? en_of(m_upd) : core_oe);
                chk(latched ? "R6 pin_out" : "R2 pin_out", 64'(pin_out), 64'(eo));
                chk(mode_highz ? "R8 pin_oe" : "R2 pin_oe", 64'(pin_oe), 64'(ee));
                chk("R4 tdo", 64'(tdo), 64'(m_chain[0]));
                chk("R2 core_in", 64'(core_in), 64'(pin_in));
            end
        end
    end

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    // capture, shift pattern in while checking serial output, then update
    task automatic scan(logic [LEN-1:0] pat, logic [LEN-1:0] exp_cap, string req);
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            tdi = pat[k];
            #1;
            chk(req, 64'(tdo), 64'(exp_cap[k]));
            tick();
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [LEN-1:0] p1, p2, cap, t_hold;
        logic [NO-1:0]  po_hold, pe_hold;
        p1 = 12'hA5C;
        p2 = 12'h3C9;

        repeat (3) tick();
        trst_n = 1'b1;
        tick();

        // R1: latches empty after reset
        mode_extest = 1'b1;
        core_out    = '1;
        core_oe     = '1;
        #1;
        chk("R1 pin_out", 64'(pin_out), 64'h0);
        chk("R1 pin_oe", 64'(pin_oe), 64'h0);
        tick();
        mode_extest = 1'b0;

        // R2: functional mode with varied traffic
        for (int k = 0; k < 6; k++) begin
            core_out = 4'(k * 5 + 3);
            core_oe  = 4'(k * 7 + 1);
            pin_in   = 4'(k * 3 + 2);
            tick();
            chk("R2 pass out", 64'(pin_out), 64'(core_out));
        end

        // R3 / R4 / R5: sample captures and preloads
        mode_sample = 1'b1;
        pin_in   = 4'b1010;
        core_out = 4'b0110;
        core_oe  = 4'b1100;
        #1;
        cap = snap();
        scan(p1, cap, "R3 capture");
        #1;
        chk("R2 sample no disturb", 64'(pin_out), 64'(core_out));
        chk("R5 sample latch via model", 64'(m_upd), 64'(p1[LEN-1:NI]));

        // R7: preloaded values present at once
        mode_sample = 1'b0;
        mode_extest = 1'b1;
        #1;
        chk("R7 first extest out", 64'(pin_out), 64'(data_of(p1[LEN-1:NI])));
        chk("R7 first extest oe", 64'(pin_oe), 64'(en_of(p1[LEN-1:NI])));
        tick();

        // R6: new scan under extest; pins hold until update
        pin_in   = 4'b0101;
        core_out = 4'b1001;
        #1;
        cap = snap();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            tdi = p2[k];
            #1;
            chk("R3 extest capture", 64'(tdo), 64'(cap[k]));
            chk("R6 hold during shift", 64'(pin_out), 64'(data_of(p1[LEN-1:NI])));
            tick();
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
        #1;
        chk("R6 extest out", 64'(pin_out), 64'(data_of(p2[LEN-1:NI])));
        chk("R6 extest oe", 64'(pin_oe), 64'(en_of(p2[LEN-1:NI])));

        // R8: high impedance over a live extest, then alone
        mode_highz = 1'b1;
        tick();
        chk("R8 over extest", 64'(pin_oe), 64'h0);
        mode_extest = 1'b0;
        core_oe     = '1;
        tick();
        chk("R8 alone", 64'(pin_oe), 64'h0);
        chk("R2 highz out", 64'(pin_out), 64'(core_out));
        mode_highz = 1'b0;

        // R9: clamp drives from latches, strobes have no effect
        mode_clamp = 1'b1;
        tick();
        t_hold  = 12'(tdo);
        po_hold = pin_out;
        pe_hold = pin_oe;
        chk("R9 clamp out", 64'(pin_out), 64'(data_of(p2[LEN-1:NI])));
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        tdi        = ~tdo;
        repeat (3) tick();
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
        tick();
        chk("R9 tdo stable", 64'(tdo), 64'(t_hold[0]));
        chk("R9 pins stable", 64'(pin_out), 64'(po_hold));
        chk("R9 oe stable", 64'(pin_oe), 64'(pe_hold));
        mode_clamp = 1'b0;

        // R11: no mode selected, strobes ignored
        t_hold = 12'(tdo);
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        tdi        = ~t_hold[0];
        repeat (2) tick();
        shift_dr = 1'b0;
        chk("R11 tdo held", 64'(tdo), 64'(t_hold[0]));
        mode_extest = 1'b1;
        tick();
        chk("R11 latches kept", 64'(pin_out), 64'(data_of(p2[LEN-1:NI])));

        // R10: test-logic-reset clears latches
        tlr = 1'b1;
        tick();
        tlr = 1'b0;
        #1;
        chk("R10 cleared out", 64'(pin_out), 64'h0);
        chk("R10 cleared oe", 64'(pin_oe), 64'h0);
        mode_extest = 1'b0;
        repeat (2) tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule